// File: doc/BRIEF.md
# Peripheral Bulk Packet Responder

This block is the peripheral end of a bulk register transfer link. A manager sends packets one byte slot at a time. Each packet opens with six header bytes (flags, byte count, start address), then a header check byte. In slot 7 the peripheral answers with a header response. The data bytes follow, then a data check byte, and finally a footer response from the peripheral.

The responder checks the header CRC and decides whether the packet is meant for this device. It then answers acceptance, rejection or busy. On a write it streams each data byte into a byte-wide register port at consecutive addresses while it accumulates the data CRC. On a read it sources the bytes from the register port, then sends its own data CRC. In both cases it reports the outcome in the footer slot. Every response byte carries a 2-bit code repeated four times.

The manager marks each slot with `slot_en` and the first byte of a packet with `rx_sop`. The responder shows what it drives through `tx_own` and `tx_byte`. Electrical turnaround and frame timing are outside this block.

Top module: `bulk_pkt_responder`

## Requirements
- R1: While `rst` is high, and after its release until the first slot, `tx_own`, `reg_we` and `reg_re` are 0.
- R2: Header CRC is CRC-8, polynomial 0x4D, initial value 0xFF, MSB first, no final XOR, taken over bytes 0..5 and compared with byte 6. On a mismatch, slot 7 is owned with 0x55 (Nak). Every later slot up to the next `rx_sop` is not owned and causes no register access.
- R3: Byte 0 layout is bit 7 active, bit 6 read (1) / write (0), bit 5 count bit 8, bits 3:0 device number. Byte 1 holds count bits 7:0. Bytes 2..5 hold the 32-bit start address, MSB first. A device number matches when it equals `dev_num`, or equals 15 (broadcast), or equals 12+g with `grp_mask[g]` set. A packet with a good CRC that does not match is never owned and causes no register access.
- R4: A matching packet with a good CRC while `busy` is high at slot 7 gets 0xAA (Not Ready) in slot 7. The rest of that packet is ignored as in R2.
- R5: A matching packet with a good CRC and `busy` low gets 0x00 (Ack) in slot 7.
- R6: An accepted active write issues one `reg_we` pulse per data byte, at addresses start, start+1, and so on, in the cycle after that byte's slot. The data slots are not owned.
- R7: The write footer is owned and holds 0x55 (Nak) when the received data check byte differs from the CRC of the data bytes (same CRC as R2). Otherwise it holds 0xFF (Bad) if any access of the packet saw `reg_err`, else 0xAA (Good).
- R8: An accepted active read owns each data slot and drives the register contents from consecutive addresses. It then owns the data check slot with the CRC of the bytes it sent, and the footer with 0xFF (Bad) on a register error or 0xAA (Good) otherwise. The register port returns `reg_rdata` and `reg_err` in the cycle after a `reg_re` or `reg_we` pulse. `reg_rdata` holds until the next read.
- R9: An accepted packet with active clear causes no register access and owns neither data nor data check slots. Its footer is owned with 0x00 (Ack).
- R10: A zero byte count places the data check in slot 8 and the footer in slot 9. A count of 256 or more uses count bit 8.
- R11: `tx_own` and `tx_byte` change only at the clock edge that samples `slot_en`. Slots are at least two cycles apart.
- R12: `rx_sop` restarts the packet at byte 0 from any point. Writes already issued stay committed.
- R13: `reg_we` and `reg_re` are never high together. Each is a one-cycle pulse in the cycle after a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_num | input | 4 | This device's assigned number |
| grp_mask | input | 2 | Group membership, bit g for group 12+g |
| busy | input | 1 | Peripheral cannot accept a packet now |
| slot_en | input | 1 | A byte slot occurs this cycle |
| rx_sop | input | 1 | This slot is byte 0 of a packet |
| rx_byte | input | 8 | Byte driven by the manager |
| tx_own | output | 1 | Peripheral drives the last slot |
| tx_byte | output | 8 | Byte driven by the peripheral |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_addr | output | 32 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, one cycle after `reg_re` |
| reg_err | input | 1 | Access error, one cycle after a strobe |

## Verification
Each slot's answer is registered at the edge that samples `slot_en`. The bench therefore checks `tx_own`/`tx_byte` at the falling edge right after that slot and before the next slot begins. Register strobes appear in the cycle after a slot. The bench's register model answers them at the next rising edge, so read data is in place for the following slot, two cycles later. Access counts and the memory image are compared after three idle cycles at the end of each packet, once every strobe and error return has settled.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 32;
  localparam int CNT_W      = 9;
  localparam int DEV_W      = 4;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int HDR_LAST   = 1 + ADDR_BYTES;  // index of last header field byte
  localparam int IDX_W      = $clog2(HDR_LAST + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_HDR, PH_HCHK, PH_HRSP, PH_DATA, PH_DCHK, PH_FOOT
  } phase_t;

  typedef logic [1:0] code_t;
  localparam code_t HC_ACK  = 2'd0;
  localparam code_t HC_NAK  = 2'd1;
  localparam code_t HC_NRDY = 2'd2;
  localparam code_t FC_ACK  = 2'd0;
  localparam code_t FC_NAK  = 2'd1;
  localparam code_t FC_GOOD = 2'd2;
  localparam code_t FC_BAD  = 2'd3;

  function automatic logic [BYTE_W-1:0] widen_code(input code_t c);
    return {(BYTE_W/2){c}};
  endfunction

  function automatic logic [7:0] crc8_next(input logic [7:0] cur,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ din[i];
      c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/bpr_crc8.sv
module bpr_crc8 import bpr_pkg::*; #(
  parameter logic [7:0] POLY = 8'h4D,
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      crc <= INIT;
    end else if (clr) begin
      crc <= en ? crc8_next(INIT, din, POLY) : INIT;
    end else if (en) begin
      crc <= crc8_next(crc, din, POLY);
    end
  end
endmodule

// File: rtl/bpr_dev_match.sv
module bpr_dev_match import bpr_pkg::*; #(
  parameter int BCAST_ID = 15,
  parameter int GRP_BASE = 12,
  parameter int NUM_GRP  = 2
) (
  input  logic [DEV_W-1:0]   dev_field,
  input  logic [DEV_W-1:0]   dev_num,
  input  logic [NUM_GRP-1:0] grp_mask,
  output logic               hit
);
  logic [NUM_GRP-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [DEV_W-1:0] GID = DEV_W'(GRP_BASE + g);
    assign grp_hit[g] = grp_mask[g] && (dev_field == GID);
  end

  assign hit = (dev_field == dev_num) ||
               (dev_field == DEV_W'(BCAST_ID)) ||
               (|grp_hit);
endmodule

// File: rtl/bulk_pkt_responder.sv
module bulk_pkt_responder import bpr_pkg::*; #(
  parameter logic [7:0] CRC_POLY = 8'h4D,
  parameter logic [7:0] CRC_INIT = 8'hFF,
  parameter int         BCAST_ID = 15,
  parameter int         GRP_BASE = 12,
  parameter int         NUM_GRP  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEV_W-1:0]   dev_num,
  input  logic [NUM_GRP-1:0] grp_mask,
  input  logic               busy,
  input  logic               slot_en,
  input  logic               rx_sop,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic               tx_own,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic               reg_we,
  output logic               reg_re,
  output logic [ADDR_W-1:0]  reg_addr,
  output logic [BYTE_W-1:0]  reg_wdata,
  input  logic [BYTE_W-1:0]  reg_rdata,
  input  logic               reg_err
);
  phase_t             ph;
  logic [IDX_W-1:0]   idx;
  logic [BYTE_W-1:0]  flags_q;
  logic [BYTE_W-1:0]  cnt_lo_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W-1:0]  cur_addr;
  logic [CNT_W-1:0]   rem;
  logic               hchk_ok;
  logic               dchk_ok;
  logic               err_q;
  logic               pend_q;

  logic [7:0]         hcrc;
  logic [7:0]         dcrc;
  logic               dev_hit;

  wire              pkt_act = flags_q[7];
  wire              pkt_rd  = flags_q[6];
  wire [CNT_W-1:0]  pkt_cnt = {flags_q[5], cnt_lo_q};
  wire              err_now = err_q | (pend_q & reg_err);
  wire              take_sop = slot_en & rx_sop;

  bpr_dev_match #(
    .BCAST_ID(BCAST_ID), .GRP_BASE(GRP_BASE), .NUM_GRP(NUM_GRP)
  ) match_i (
    .dev_field(flags_q[DEV_W-1:0]),
    .dev_num  (dev_num),
    .grp_mask (grp_mask),
    .hit      (dev_hit)
  );

  bpr_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) hdr_crc_i (
    .clk(clk), .rst(rst),
    .clr(take_sop),
    .en (slot_en & (rx_sop | (ph == PH_HDR))),
    .din(rx_byte),
    .crc(hcrc)
  );

  bpr_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) dat_crc_i (
    .clk(clk), .rst(rst),
    .clr(slot_en & ~rx_sop & (ph == PH_HRSP)),
    .en (slot_en & ~rx_sop & (ph == PH_DATA) & pkt_act),
    .din(pkt_rd ? reg_rdata : rx_byte),
    .crc(dcrc)
  );

  // error accumulation: the register port answers one cycle after a strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= reg_we | reg_re;
      if (slot_en && !rx_sop && ph == PH_HRSP) err_q <= 1'b0;
      else if (pend_q && reg_err)             err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      idx       <= '0;
      flags_q   <= '0;
      cnt_lo_q  <= '0;
      addr_q    <= '0;
      cur_addr  <= '0;
      rem       <= '0;
      hchk_ok   <= 1'b0;
      dchk_ok   <= 1'b0;
      tx_own    <= 1'b0;
      tx_byte   <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (slot_en) begin
        tx_own <= 1'b0;
        if (rx_sop) begin
          flags_q <= rx_byte;
          idx     <= IDX_W'(1);
          ph      <= PH_HDR;
        end else begin
          unique case (ph)
            PH_IDLE: ;
            PH_HDR: begin
              if (idx == IDX_W'(1)) cnt_lo_q <= rx_byte;
              else                  addr_q   <= {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
              if (idx == IDX_W'(HDR_LAST)) ph <= PH_HCHK;
              idx <= idx + IDX_W'(1);
            end
            PH_HCHK: begin
              hchk_ok <= (rx_byte == hcrc);
              ph      <= PH_HRSP;
            end
            PH_HRSP: begin
              if (!hchk_ok) begin
                tx_own  <= 1'b1;
                tx_byte <= widen_code(HC_NAK);
                ph      <= PH_IDLE;
              end else if (!dev_hit) begin
                ph <= PH_IDLE;
              end else if (busy) begin
                tx_own  <= 1'b1;
                tx_byte <= widen_code(HC_NRDY);
                ph      <= PH_IDLE;
              end else begin
                tx_own   <= 1'b1;
                tx_byte  <= widen_code(HC_ACK);
                rem      <= pkt_cnt;
                cur_addr <= addr_q;
                ph       <= (pkt_cnt == '0) ? PH_DCHK : PH_DATA;
                if (pkt_act && pkt_rd && pkt_cnt != '0) begin
                  reg_re   <= 1'b1;
                  reg_addr <= addr_q;
                  cur_addr <= addr_q + ADDR_W'(1);
                end
              end
            end
            PH_DATA: begin
              rem <= rem - CNT_W'(1);
              if (rem == CNT_W'(1)) ph <= PH_DCHK;
              if (pkt_act) begin
                if (pkt_rd) begin
                  tx_own  <= 1'b1;
                  tx_byte <= reg_rdata;
                  if (rem != CNT_W'(1)) begin
                    reg_re   <= 1'b1;
                    reg_addr <= cur_addr;
                    cur_addr <= cur_addr + ADDR_W'(1);
                  end
                end else begin
                  reg_we    <= 1'b1;
                  reg_addr  <= cur_addr;
                  reg_wdata <= rx_byte;
                  cur_addr  <= cur_addr + ADDR_W'(1);
                end
              end
            end
            PH_DCHK: begin
              dchk_ok <= (rx_byte == dcrc);
              if (pkt_act && pkt_rd) begin
                tx_own  <= 1'b1;
                tx_byte <= dcrc;
              end
              ph <= PH_FOOT;
            end
            PH_FOOT: begin
              tx_own <= 1'b1;
              if (!pkt_act)     tx_byte <= widen_code(FC_ACK);
              else if (pkt_rd)  tx_byte <= widen_code(err_now ? FC_BAD : FC_GOOD);
              else if (!dchk_ok) tx_byte <= widen_code(FC_NAK);
              else              tx_byte <= widen_code(err_now ? FC_BAD : FC_GOOD);
              ph <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bulk_pkt_responder_chk.sv
module bulk_pkt_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       slot_en,
  input logic       tx_own,
  input logic [7:0] tx_byte,
  input logic       reg_we,
  input logic       reg_re
);
  // R13
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));

  // R13
  we_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(slot_en));

  // R8
  re_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    reg_re |-> $past(slot_en));

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_en) |-> ($stable(tx_own) && $stable(tx_byte)));

  // R13
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we || reg_re) |=> !(reg_we || reg_re));
endmodule

bind bulk_pkt_responder bulk_pkt_responder_chk chk_i (
  .clk    (clk),
  .rst    (rst),
  .slot_en(slot_en),
  .tx_own (tx_own),
  .tx_byte(tx_byte),
  .reg_we (reg_we),
  .reg_re (reg_re)
);

// File: tb/bulk_pkt_responder_tb_top.sv
module bulk_pkt_responder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  dev_num = 4'd5;
  logic [1:0]  grp_mask = 2'b01;
  logic        busy = 1'b0;
  logic        slot_en = 1'b0;
  logic        rx_sop = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tx_own;
  logic [7:0]  tx_byte;
  logic        reg_we, reg_re;
  logic [31:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = 8'h00;
  logic        reg_err = 1'b0;

  logic [7:0]  mem     [0:255];
  logic [7:0]  exp_mem [0:255];
  int          n_chk = 0;
  int          n_fail = 0;
  int          acc_cnt = 0;
  int          cyc = 0;
  localparam logic [7:0] BAD_ADDR = 8'hEE;

  always #4 clk = ~clk;

  bulk_pkt_responder dut_i (
    .clk(clk), .rst(rst), .dev_num(dev_num), .grp_mask(grp_mask),
    .busy(busy), .slot_en(slot_en), .rx_sop(rx_sop), .rx_byte(rx_byte),
    .tx_own(tx_own), .tx_byte(tx_byte), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_err(reg_err)
  );

  // register file model: one-cycle read latency, error one cycle after strobe
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_we) mem[reg_addr[7:0]] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr[7:0]];
    reg_err <= (reg_we || reg_re) && (reg_addr[7:0] == BAD_ADDR);
    if (reg_we || reg_re) acc_cnt <= acc_cnt + 1;
  end

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[7] ^ d[b]) r = (r << 1) ^ 8'h4D;
      else             r = r << 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit sop);
    @(negedge clk);
    slot_en = 1'b1; rx_byte = b; rx_sop = sop;
    @(negedge clk);
    slot_en = 1'b0; rx_sop = 1'b0;
  endtask

  task automatic expect_slot(input bit own, input logic [7:0] val, input string tag);
    if (own) chk(tx_own === 1'b1 && tx_byte === val, tag, {tx_own, tx_byte}, {1'b1, val});
    else     chk(tx_own === 1'b0, tag, {tx_own, tx_byte}, {1'b0, 8'h00});
  endtask

  task automatic run_pkt(input bit act, input bit rd, input logic [3:0] dev,
                         input int cnt, input logic [31:0] addr,
                         input bit bad_h, input bit bad_d, input bit bsy,
                         input int stop);
    logic [7:0] hb [6];
    logic [7:0] hc, dc, db, a, code;
    logic [8:0] c9;
    bit hit, acc, err;
    int nslots, base_acc, exp_acc, k;
    string itag;
    c9 = 9'(cnt);
    hb[0] = {act, rd, c9[8], 1'b0, dev};
    hb[1] = c9[7:0];
    hb[2] = addr[31:24]; hb[3] = addr[23:16]; hb[4] = addr[15:8]; hb[5] = addr[7:0];
    hc = 8'hFF;
    for (int j = 0; j < 6; j++) hc = crc_upd(hc, hb[j]);
    if (bad_h) hc = hc ^ 8'h01;
    hit = (dev == 4'd5) || (dev == 4'd15) || (dev == 4'd12);
    acc = !bad_h && hit && !bsy;
    itag = bad_h ? "R2" : (!hit ? "R3" : (bsy ? "R4" : "R9"));
    nslots = (stop > 0) ? stop : cnt + 10;
    base_acc = acc_cnt; exp_acc = 0; err = 1'b0; dc = 8'hFF;
    busy = bsy;
    for (int i = 0; i < nslots; i++) begin
      if (i < 6) begin
        put(hb[i], i == 0); expect_slot(1'b0, 8'h00, "R11");
      end else if (i == 6) begin
        put(hc, 1'b0); expect_slot(1'b0, 8'h00, "R11");
      end else if (i == 7) begin
        put(8'h00, 1'b0);
        if (bad_h)     expect_slot(1'b1, 8'h55, "R2");
        else if (!hit) expect_slot(1'b0, 8'h00, "R3");
        else if (bsy)  expect_slot(1'b1, 8'hAA, "R4");
        else           expect_slot(1'b1, 8'h00, "R5");
        if (acc && act && rd && cnt > 0) begin
          exp_acc++;
          if (addr[7:0] == BAD_ADDR) err = 1'b1;
        end
      end else if (i < 8 + cnt) begin
        k = i - 8;
        a = addr[7:0] + 8'(k);
        if (acc && act && !rd) begin
          db = 8'($urandom);
          put(db, 1'b0); expect_slot(1'b0, 8'h00, "R6");
          exp_mem[a] = db; dc = crc_upd(dc, db); exp_acc++;
          if (a == BAD_ADDR) err = 1'b1;
        end else if (acc && act && rd) begin
          put(8'($urandom), 1'b0); expect_slot(1'b1, exp_mem[a], "R8");
          dc = crc_upd(dc, exp_mem[a]);
          if (k != cnt - 1) begin
            exp_acc++;
            if (a + 8'd1 == BAD_ADDR) err = 1'b1;
          end
        end else begin
          put(8'($urandom), 1'b0); expect_slot(1'b0, 8'h00, itag);
        end
      end else if (i == 8 + cnt) begin
        if (acc && act && !rd) begin
          put(bad_d ? (dc ^ 8'h01) : dc, 1'b0); expect_slot(1'b0, 8'h00, "R10");
        end else if (acc && act && rd) begin
          put(8'($urandom), 1'b0); expect_slot(1'b1, dc, "R8");
        end else begin
          put(8'($urandom), 1'b0); expect_slot(1'b0, 8'h00, itag);
        end
      end else begin
        put(8'($urandom), 1'b0);
        if (!acc) expect_slot(1'b0, 8'h00, itag);
        else begin
          if (!act)      code = 8'h00;
          else if (rd)   code = err ? 8'hFF : 8'hAA;
          else if (bad_d) code = 8'h55;
          else           code = err ? 8'hFF : 8'hAA;
          expect_slot(1'b1, code, !act ? "R9" : (rd ? "R8" : "R7"));
        end
      end
    end
    busy = 1'b0;
    repeat (3) @(negedge clk);
    // R13 / R6 / R8: number of register accesses issued by this packet
    chk(acc_cnt - base_acc == exp_acc, "R13", 9'(acc_cnt - base_acc), 9'(exp_acc));
    k = 0;
    for (int m = 0; m < 256; m++) if (mem[m] !== exp_mem[m]) k++;
    chk(k == 0, "R6", 9'(k), 9'd0);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240607);
    for (int m = 0; m < 256; m++) begin
      mem[m] = 8'($urandom); exp_mem[m] = mem[m];
    end
    repeat (3) @(negedge clk);
    chk(tx_own === 1'b0 && reg_we === 1'b0 && reg_re === 1'b0, "R1",
        {tx_own, reg_we, reg_re, 6'd0}, 9'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_own === 1'b0 && reg_we === 1'b0 && reg_re === 1'b0, "R1",
        {tx_own, reg_we, reg_re, 6'd0}, 9'd0);

    run_pkt(1, 0, 4'd5, 6, 32'h0000_1010, 0, 0, 0, 0);   // R6 R7 write good
    run_pkt(1, 1, 4'd5, 6, 32'h0000_1010, 0, 0, 0, 0);   // R8 read back
    run_pkt(1, 0, 4'd5, 4, 32'h0000_2020, 1, 0, 0, 0);   // R2 header CRC bad
    run_pkt(1, 0, 4'd3, 4, 32'h0000_3030, 0, 0, 0, 0);   // R3 other device
    run_pkt(1, 0, 4'd15, 3, 32'h0000_4040, 0, 0, 0, 0);  // R3 broadcast
    run_pkt(1, 1, 4'd12, 3, 32'h0000_4040, 0, 0, 0, 0);  // R3 member group
    run_pkt(1, 0, 4'd13, 3, 32'h0000_5050, 0, 0, 0, 0);  // R3 non-member group
    run_pkt(1, 0, 4'd5, 3, 32'h0000_6060, 0, 0, 1, 0);   // R4 busy
    run_pkt(0, 0, 4'd5, 5, 32'h0000_7070, 0, 0, 0, 0);   // R9 inactive write
    run_pkt(0, 1, 4'd5, 5, 32'h0000_7070, 0, 0, 0, 0);   // R9 inactive read
    run_pkt(1, 0, 4'd5, 4, 32'h0000_8080, 0, 1, 0, 0);   // R7 data CRC bad
    run_pkt(1, 0, 4'd5, 4, 32'h0000_00EC, 0, 0, 0, 0);   // R7 register error
    run_pkt(1, 1, 4'd5, 4, 32'h0000_00EB, 0, 0, 0, 0);   // R8 register error
    run_pkt(1, 0, 4'd5, 0, 32'h0000_9090, 0, 0, 0, 0);   // R10 empty write
    run_pkt(1, 1, 4'd5, 0, 32'h0000_9090, 0, 0, 0, 0);   // R10 empty read
    run_pkt(1, 0, 4'd5, 300, 32'h0000_0000, 0, 0, 0, 0); // R10 long count
    run_pkt(1, 0, 4'd5, 10, 32'h0000_A0A0, 0, 0, 0, 11); // R12 cut after 3 writes
    run_pkt(1, 1, 4'd5, 5, 32'h0000_A0A0, 0, 0, 0, 0);   // R12 restart, read back
    run_pkt(1, 0, 4'd5, 2, 32'h0000_B0B0, 0, 0, 0, 3);   // R12 cut in header

    for (int r = 0; r < 40; r++) begin
      logic [3:0] dv;
      int sel;
      sel = int'($urandom_range(0, 4));
      dv = (sel == 0) ? 4'd5 : (sel == 1) ? 4'd15 : (sel == 2) ? 4'd12 :
           (sel == 3) ? 4'd13 : 4'd5;
      run_pkt($urandom_range(0, 9) != 0, 1'($urandom), dv,
              int'($urandom_range(0, 40)), $urandom,
              $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
              $urandom_range(0, 9) == 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule